// File: doc/BRIEF.md
# Byte-Parity Shared Memory Write/Check Unit

This unit stands between the masters of a shared memory (local processors and VMEbus slave traffic) and a memory word of 32 data bits and 4 parity bits. It uses odd parity, with one parity bit for each 8-bit byte lane. A write of a whole, aligned 32-bit word goes to memory in one cycle, with four freshly generated parity bits. Any narrower or misaligned write first fetches the stored word. The unit then writes only the addressed lanes and stores a parity nibble that merges the new bits for the written lanes with the old bits for the others.

Every read fetches the full word and its parity. The unit rebuilds the parity from the fetched data and compares it with the stored bits, but only on the lanes the master asked for. The master flag sets how a mismatch is reported. A VMEbus master gets a bus-error strobe in place of the normal termination. A local master gets normal termination, and the unit also raises an interrupt request at a programmable 3-bit level. In both cases the address of the first failing access is latched until software clears it. Writes are posted: the master sees termination before the memory update has finished.

The memory sits outside the block as a synchronous array. A read strobe returns the word and its parity one cycle later. Per-lane data strobes and a common parity strobe write it.

Top module: `pmem_unit`

## Requirements
- R1: Every parity bit written to memory is odd parity over its lane: lane i is data bits [8i+7:8i] with parity bit i, and each lane written together with its parity bit holds an odd number of ones.
- R2: A write with size long (req_size=2), address bits [1:0]=0 and req_be=1111 drives mem_we=1111 and mem_pwe in the cycle after acceptance, asserts rsp_term in that same cycle, and issues no memory read.
- R3: Every other write issues exactly one mem_rd in the cycle after acceptance, with rsp_term in that same cycle (posted, before the memory update). In the following cycle it drives mem_we=req_be and mem_pwe. Parity for enabled lanes is freshly generated and parity for the other lanes is copied from the fetched mem_rpar. Data in lanes that are not enabled stays unchanged.
- R4: A read issues one mem_rd in the cycle after acceptance. Two cycles after acceptance it gives exactly one response strobe (rsp_term or rsp_berr, never both), with rsp_rdata equal to the full fetched 32-bit word.
- R5: A read reports a parity error only when a lane enabled in req_be has a mismatch between the regenerated and the stored parity. Mismatches on lanes that are not enabled are ignored.
- R6: A read with an error by a VMEbus master (req_vme=1) answers with rsp_berr and no rsp_term.
- R7: A read with an error by a local master (req_vme=0) answers with rsp_term and no rsp_berr, and sets a pending interrupt.
- R8: While an interrupt is pending, irq_level equals cfg_irq_level. Otherwise it is 0, so a level of 0 disables the request. err_clr removes the pending interrupt.
- R9: The first parity error sets err_valid and latches the full byte address of the access into err_addr. Later errors do not change err_addr until err_clr clears err_valid.
- R10: req_ready is high only when the unit is idle. It drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vme | input | 1 | 1 = VMEbus master, 0 = local master |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_be | input | LANES | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_term | output | 1 | Normal termination strobe |
| rsp_berr | output | 1 | Bus-error strobe |
| rsp_rdata | output | 32 | Read data, valid with the response strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | LANES | Memory data write strobe per lane |
| mem_pwe | output | 1 | Memory parity write strobe (all four bits) |
| mem_wdata | output | 32 | Data to memory |
| mem_wpar | output | LANES | Parity to memory |
| mem_rdata | input | 32 | Data from memory, one cycle after mem_rd |
| mem_rpar | input | LANES | Parity from memory, one cycle after mem_rd |
| cfg_irq_level | input | 3 | Interrupt level, 0 disables |
| err_clr | input | 1 | Clears the error latch and the pending interrupt |
| irq_level | output | 3 | Active interrupt request level, 0 when none |
| err_valid | output | 1 | An error address is held |
| err_addr | output | ADDR_W | Byte address of the first error |

## Verification
The bench corrupts stored parity bits and then reads with lane masks that either include or avoid the bad lane. A checker that ignored req_be would flag clean reads, and one that compared too few lanes would miss real errors. Partial writes are thrown over words with corrupted parity, so a merge that regenerated all four bits, or that took the old bits for the written lanes, would leave memory different from the bench shadow. Errors from both master kinds, with the interrupt level set to zero and then to non-zero, and a second error while the first is still latched, show whether the strobe is routed wrongly, the level gate is wrong or the latched address is overwritten.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_FULL  = 3'd1,
        ST_RD_PAR   = 3'd2,
        ST_WR_MERGE = 3'd3,
        ST_RD_FETCH = 3'd4,
        ST_RD_CHECK = 3'd5
    } pstate_e;

endpackage

// File: rtl/pmem_pargen.sv
module pmem_pargen #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    output logic [LANES-1:0]        par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // odd parity: lane plus bit carries an odd count of ones
        assign par[g] = ~^data[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pmem_lane_chk.sv
module pmem_lane_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic [LANES-1:0]        stored_par,
    input  logic [LANES-1:0]        lane_en,
    output logic                    err_any
);
    logic [LANES-1:0] regen;
    logic [LANES-1:0] bad_lane;

    pmem_pargen #(.LANES(LANES), .LANE_W(LANE_W)) u_regen (
        .data (data),
        .par  (regen)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign bad_lane[g] = lane_en[g] & (regen[g] ^ stored_par[g]);
    end

    assign err_any = |bad_lane;
endmodule

// File: rtl/pmem_err_log.sv
module pmem_err_log #(
    parameter int ADDR_W = 24,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              evt_local,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              clr,
    input  logic [LVL_W-1:0]  cfg_level,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic [LVL_W-1:0]  irq_level
);
    logic irq_pend;

    // an error event in the same cycle as a clear takes precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_addr  <= '0;
            irq_pend  <= 1'b0;
        end else if (evt) begin
            if (!err_valid) begin
                err_valid <= 1'b1;
                err_addr  <= evt_addr;
            end
            if (evt_local) begin
                irq_pend <= 1'b1;
            end
        end else if (clr) begin
            err_valid <= 1'b0;
            irq_pend  <= 1'b0;
        end
    end

    assign irq_level = irq_pend ? cfg_level : '0;
endmodule

// File: rtl/pmem_unit.sv
module pmem_unit
    import pmem_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int LVL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_vme,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic [LANES-1:0]         req_be,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    output logic                     rsp_term,
    output logic                     rsp_berr,
    output logic [LANES*LANE_W-1:0]  rsp_rdata,
    output logic [ADDR_W-$clog2(LANES)-1:0] mem_addr,
    output logic                     mem_rd,
    output logic [LANES-1:0]         mem_we,
    output logic                     mem_pwe,
    output logic [LANES*LANE_W-1:0]  mem_wdata,
    output logic [LANES-1:0]         mem_wpar,
    input  logic [LANES*LANE_W-1:0]  mem_rdata,
    input  logic [LANES-1:0]         mem_rpar,
    input  logic [LVL_W-1:0]         cfg_irq_level,
    input  logic                     err_clr,
    output logic [LVL_W-1:0]         irq_level,
    output logic                     err_valid,
    output logic [ADDR_W-1:0]        err_addr
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    pstate_e             st, st_nx;
    logic [ADDR_W-1:0]   q_addr;
    logic [LANES-1:0]    q_be;
    logic [DATA_W-1:0]   q_wdata;
    logic                q_vme;

    logic [LANES-1:0]    new_par;
    logic                chk_err;
    logic                err_evt;
    logic                full_write;

    assign full_write = (req_size == SZ_LONG)
                     && (req_addr[OFF_W-1:0] == '0)
                     && (req_be == '1);

    pmem_pargen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
        .data (q_wdata),
        .par  (new_par)
    );

    pmem_lane_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk_lanes (
        .data       (mem_rdata),
        .stored_par (mem_rpar),
        .lane_en    (q_be),
        .err_any    (chk_err)
    );

    pmem_err_log #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (err_evt),
        .evt_local (~q_vme),
        .evt_addr  (q_addr),
        .clr       (err_clr),
        .cfg_level (cfg_irq_level),
        .err_valid (err_valid),
        .err_addr  (err_addr),
        .irq_level (irq_level)
    );

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            q_addr  <= '0;
            q_be    <= '0;
            q_wdata <= '0;
            q_vme   <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && req_valid) begin
                q_addr  <= req_addr;
                q_be    <= req_be;
                q_wdata <= req_wdata;
                q_vme   <= req_vme;
            end
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)     st_nx = ST_RD_FETCH;
                    else if (full_write) st_nx = ST_WR_FULL;
                    else                st_nx = ST_RD_PAR;
                end
            end
            ST_WR_FULL:  st_nx = ST_IDLE;
            ST_RD_PAR:   st_nx = ST_WR_MERGE;
            ST_WR_MERGE: st_nx = ST_IDLE;
            ST_RD_FETCH: st_nx = ST_RD_CHECK;
            ST_RD_CHECK: st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_term  = 1'b0;
        rsp_berr  = 1'b0;
        rsp_rdata = '0;
        mem_rd    = 1'b0;
        mem_we    = '0;
        mem_pwe   = 1'b0;
        mem_wpar  = '0;
        err_evt   = 1'b0;
        unique case (st)
            ST_IDLE: req_ready = 1'b1;
            ST_WR_FULL: begin
                mem_we   = '1;
                mem_pwe  = 1'b1;
                mem_wpar = new_par;
                rsp_term = 1'b1;
            end
            ST_RD_PAR: begin
                mem_rd   = 1'b1;
                rsp_term = 1'b1;
            end
            ST_WR_MERGE: begin
                mem_we   = q_be;
                mem_pwe  = 1'b1;
                mem_wpar = (new_par & q_be) | (mem_rpar & ~q_be);
            end
            ST_RD_FETCH: mem_rd = 1'b1;
            ST_RD_CHECK: begin
                rsp_rdata = mem_rdata;
                err_evt   = chk_err;
                if (chk_err && q_vme) rsp_berr = 1'b1;
                else                  rsp_term = 1'b1;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign mem_addr  = q_addr[ADDR_W-1:OFF_W];
    assign mem_wdata = q_wdata;
endmodule

// File: rtl/pmem_unit_chk.sv
module pmem_unit_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    rsp_term,
    input logic                    rsp_berr,
    input logic                    mem_rd,
    input logic [LANES-1:0]        mem_we,
    input logic                    mem_pwe,
    input logic [LANES*LANE_W-1:0] mem_wdata,
    input logic [LANES-1:0]        mem_wpar,
    input logic                    q_vme,
    input logic [LVL_W-1:0]        cfg_irq_level,
    input logic [LVL_W-1:0]        irq_level,
    input logic                    err_clr,
    input logic                    err_valid,
    input logic [ADDR_W-1:0]       err_addr
);
    logic [LANES-1:0] lane_odd;
    for (genvar g = 0; g < LANES; g++) begin : g_odd
        assign lane_odd[g] = ^{mem_wdata[g*LANE_W +: LANE_W], mem_wpar[g]};
    end

    a_r1_odd_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pwe |-> ((lane_odd & mem_we) == mem_we));

    a_r2_no_read_while_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pwe |-> !mem_rd);

    a_r3_merge_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pwe && (mem_we != '1)) |-> $past(mem_rd));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_term && rsp_berr));

    a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_term || rsp_berr) |=> !(rsp_term || rsp_berr));

    a_r6_berr_vme_only: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_berr |-> q_vme);

    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_level == cfg_irq_level));

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && $past(err_valid) && !$past(err_clr)) |-> (err_addr == $past(err_addr)));

    a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);
endmodule

bind pmem_unit pmem_unit_chk #(
    .LANES(LANES), .LANE_W(LANE_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)
) u_pmem_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_term      (rsp_term),
    .rsp_berr      (rsp_berr),
    .mem_rd        (mem_rd),
    .mem_we        (mem_we),
    .mem_pwe       (mem_pwe),
    .mem_wdata     (mem_wdata),
    .mem_wpar      (mem_wpar),
    .q_vme         (q_vme),
    .cfg_irq_level (cfg_irq_level),
    .irq_level     (irq_level),
    .err_clr       (err_clr),
    .err_valid     (err_valid),
    .err_addr      (err_addr)
);

// File: tb/tb_pmem_unit.sv
module tb_pmem_unit;
    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_vme;
    logic [AW-1:0] req_addr;
    logic [1:0]  req_size;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        rsp_term, rsp_berr;
    logic [31:0] rsp_rdata;
    logic [AW-3:0] mem_addr;
    logic        mem_rd, mem_pwe;
    logic [3:0]  mem_we, mem_wpar, mem_rpar;
    logic [31:0] mem_wdata, mem_rdata;
    logic [2:0]  cfg_irq_level, irq_level;
    logic        err_clr, err_valid;
    logic [AW-1:0] err_addr;

    always #4 clk = ~clk;

    pmem_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_vme(req_vme), .req_addr(req_addr),
        .req_size(req_size), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_term(rsp_term), .rsp_berr(rsp_berr), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_pwe(mem_pwe),
        .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_rdata(mem_rdata),
        .mem_rpar(mem_rpar), .cfg_irq_level(cfg_irq_level), .err_clr(err_clr),
        .irq_level(irq_level), .err_valid(err_valid), .err_addr(err_addr)
    );

    // external memory model, with a parity corruption port for the bench
    logic [31:0] mdata [16];
    logic [3:0]  mpar  [16];
    logic [31:0] rd_q;
    logic [3:0]  rp_q;
    logic        inj_en;
    logic [3:0]  inj_word, inj_mask;

    always @(posedge clk) begin
        if (mem_rd) begin
            rd_q <= mdata[mem_addr[3:0]];
            rp_q <= mpar[mem_addr[3:0]];
        end
        for (int i = 0; i < 4; i++)
            if (mem_we[i]) mdata[mem_addr[3:0]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
        if (mem_pwe) mpar[mem_addr[3:0]] <= mem_wpar;
        if (inj_en) mpar[inj_word] <= mpar[inj_word] ^ inj_mask;
    end
    assign mem_rdata = rd_q;
    assign mem_rpar  = rp_q;

    // shadow of expected memory contents
    logic [31:0] sdata [16];
    logic [3:0]  spar  [16];

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    int  tn, rcount;
    bit  got_berr, rdy_n1;
    logic [31:0] got_rdata;

    function automatic logic [3:0] oddp(input logic [31:0] d);
        for (int i = 0; i < 4; i++) oddp[i] = ~^d[i*8 +: 8];
    endfunction

    function automatic logic [3:0] make_be(input logic [1:0] sz, input logic [1:0] off);
        logic [3:0] m;
        if (sz == 2'd0)      m = 4'b0001 << off;
        else if (sz == 2'd1) m = 4'b0011 << off;
        else                 m = 4'b1111 << off;
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit vme, input logic [3:0] word,
                          input logic [1:0] off, input logic [1:0] sz,
                          input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vme = vme;
        req_addr = {18'd0, word, off}; req_size = sz; req_be = be; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        tn = 0; rcount = 0; got_berr = 1'b0; got_rdata = '0; rdy_n1 = 1'b1;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            if (n == 1) rdy_n1 = req_ready;
            if (mem_rd) rcount++;
            if ((rsp_term || rsp_berr) && tn == 0) begin
                tn = n; got_berr = rsp_berr; got_rdata = rsp_rdata;
            end
        end
    endtask

    task automatic do_write(input bit vme, input logic [3:0] word, input logic [1:0] off,
                            input logic [1:0] sz, input logic [31:0] wd);
        logic [3:0] be;
        logic [3:0] np;
        bit full;
        be = make_be(sz, off);
        full = (sz == 2'd2) && (off == 2'd0);
        np = oddp(wd);
        for (int i = 0; i < 4; i++)
            if (be[i]) begin
                sdata[word][i*8 +: 8] = wd[i*8 +: 8];
                spar[word][i] = np[i];
            end
        access(1'b1, vme, word, off, sz, be, wd);
        check(tn == 1 && !got_berr, full ? "R2 term cycle" : "R3 posted term cycle", tn, 1);
        check(rcount == (full ? 0 : 1), full ? "R2 no memory read" : "R3 one memory read", rcount, full ? 0 : 1);
        check(mdata[word] == sdata[word], full ? "R2 stored data" : "R3 lane-masked data", mdata[word], sdata[word]);
        check(mpar[word] == spar[word], full ? "R1 fresh parity" : "R3 merged parity", mpar[word], spar[word]);
    endtask

    task automatic do_read(input bit vme, input logic [3:0] word, input logic [1:0] off,
                           input logic [1:0] sz, output bit exp_err);
        logic [3:0] be;
        be = make_be(sz, off);
        exp_err = |(be & (oddp(sdata[word]) ^ spar[word]));
        access(1'b0, vme, word, off, sz, be, 32'd0);
        check(tn == 2, "R4 response cycle", tn, 2);
        check(rcount == 1, "R4 one fetch", rcount, 1);
        check(got_rdata == sdata[word], "R4 full word data", got_rdata, sdata[word]);
        check(got_berr == (exp_err && vme), exp_err ? (vme ? "R6 berr on vme error" : "R7 term on local error")
                                                    : "R5 no error reported", got_berr, exp_err && vme);
    endtask

    task automatic corrupt(input logic [3:0] word, input logic [3:0] mask);
        @(negedge clk);
        inj_en = 1'b1; inj_word = word; inj_mask = mask;
        @(negedge clk);
        inj_en = 1'b0;
        spar[word] = spar[word] ^ mask;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        int unsigned s;
        bit e;
        logic [1:0] sz, off;
        s = $urandom(32'd4242);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vme = 1'b0;
        req_addr = '0; req_size = '0; req_be = '0; req_wdata = '0;
        cfg_irq_level = 3'd5; err_clr = 1'b0;
        inj_en = 1'b0; inj_word = '0; inj_mask = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_term && !rsp_berr, "R10 reset idle", {req_ready, rsp_term, rsp_berr}, 3'b100);
        check(!err_valid && irq_level == 0, "R9 reset error state", {err_valid, irq_level}, 0);
        check(!mem_rd && mem_we == 0 && !mem_pwe, "R2 reset strobes", {mem_rd, mem_we, mem_pwe}, 0);

        // fill memory with aligned full writes
        for (int w = 0; w < 16; w++) do_write(w[0], w[3:0], 2'd0, 2'd2, $urandom);
        check(rdy_n1 == 1'b0, "R10 ready low after accept", rdy_n1, 0);

        // random partial writes
        for (int k = 0; k < 40; k++) begin
            sz = 2'($urandom_range(0, 2));
            if (sz == 2'd0)      off = 2'($urandom_range(0, 3));
            else if (sz == 2'd1) off = 2'($urandom_range(0, 1) * 2);
            else                 off = 2'($urandom_range(1, 3));
            do_write($urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)), off, sz, $urandom);
        end

        // random clean reads of every size
        for (int k = 0; k < 40; k++) begin
            sz = 2'($urandom_range(0, 2));
            off = (sz == 2'd2) ? 2'd0 : ((sz == 2'd1) ? 2'($urandom_range(0, 1) * 2) : 2'($urandom_range(0, 3)));
            do_read($urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)), off, sz, e);
            check(!e && !err_valid, "R5 clean read", err_valid, 0);
        end

        // corrupted lane 2 of word 3: a byte read of lane 0 must pass
        corrupt(4'd3, 4'b0100);
        do_read(1'b0, 4'd3, 2'd0, 2'd0, e);
        check(!err_valid && irq_level == 0, "R5 masked lane ignored", err_valid, 0);

        // local word read covering lane 2
        do_read(1'b0, 4'd3, 2'd2, 2'd1, e);
        check(e, "R7 error expected", e, 1);
        check(err_valid && err_addr == 24'h00000E, "R9 first error address", err_addr, 24'h00000E);
        check(irq_level == 3'd5, "R8 irq at level", irq_level, 5);

        // VMEbus error on word 5 lane 0 while the first is latched
        corrupt(4'd5, 4'b0001);
        do_read(1'b1, 4'd5, 2'd0, 2'd2, e);
        check(e, "R6 error expected", e, 1);
        check(err_addr == 24'h00000E, "R9 address held", err_addr, 24'h00000E);

        clear_err();
        @(negedge clk);
        check(!err_valid && irq_level == 0, "R8 clear", {err_valid, irq_level}, 0);

        // VMEbus error alone raises no interrupt
        do_read(1'b1, 4'd5, 2'd0, 2'd0, e);
        check(err_valid && err_addr == 24'h000014 && irq_level == 0, "R6 vme no irq", {err_valid, irq_level}, 4'b1000);
        clear_err();

        // level zero disables the request
        cfg_irq_level = 3'd0;
        do_read(1'b0, 4'd3, 2'd2, 2'd0, e);
        check(err_valid && irq_level == 0, "R8 level zero", irq_level, 0);
        @(negedge clk);
        cfg_irq_level = 3'd3;
        @(negedge clk);
        check(irq_level == 3'd3, "R8 level follows config", irq_level, 3);
        clear_err();

        // partial write over a corrupted word: bad lane 0 of word 5 is kept, lane 1 rewritten
        do_write(1'b0, 4'd5, 2'd1, 2'd0, $urandom);
        check(mpar[5][0] != oddp(mdata[5])[0], "R3 old lane parity copied", mpar[5], spar[5]);
        // rewriting lane 2 of word 3 repairs it
        do_write(1'b1, 4'd3, 2'd2, 2'd0, $urandom);
        do_read(1'b1, 4'd3, 2'd0, 2'd2, e);
        check(!e && !err_valid, "R3 repaired lane", err_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule